// File: doc/BRIEF.md
# Cascadable BCD Decade Counter

This block counts one decimal digit. Its register steps through 0 to 9 on each rising clock edge where the enable input is high, returns to 0 after 9, and holds its value when the enable is low. A synchronous, active-high clear outranks every other input. Two combinational outputs show where the digit stands. The terminal flag is high while the digit reads nine. The carry output is that flag ANDed with the incoming enable.

Several copies chain into a multi-digit decimal counter. Clock and clear go to every stage in parallel, and each stage's carry output drives the enable of the next, more significant stage. The digit width comes from the last legal value. The four-bit register has six codes that the count never reaches. If the register ever holds one of them, the flags stay low and the next enabled edge returns it to 0. The register holds a known value from power-up, which is 0 by default.

Top module: `decade_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `q` becomes 0 whatever `ce` is, and `tc` and `ceo` read 0 afterwards.
- R2: With `rst` low and `ce` high, a rising edge advances `q` by one for values 0 through 8.
- R3: With `rst` low and `ce` low, `q` keeps its value across rising edges.
- R4: With `rst` low, `ce` high and `q` = 9 (binary 1001), the next rising edge sets `q` to 0.
- R5: `tc` is 1 exactly when `q` = 9 (binary 1001), whatever `ce` is.
- R6: `ceo` equals `tc` AND `ce`, combinationally, within the same cycle.
- R7: For the codes 10 to 15 (binary 1010 to 1111), including 1011, 1101 and 1111, `tc` and `ceo` are 0 even when `ce` is high.
- R8: From a code of 10 to 15, the first rising edge with `ce` high sets `q` to 0, which is within two enabled edges. The code is held while `ce` is low, and a `rst` edge clears it at once.
- R9: Before the first clock edge, `q` holds the parameter `INIT_VALUE`, which defaults to 0.
- R10: Three stages chained carry-to-enable, with `ce` high on the first stage, count the decimal value from 000 to 999 and then return to 000. The last stage's `ceo` is high only at 999.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous clear, active high, highest priority |
| ce | input | 1 | Count enable |
| q | output | 4 | Current digit value, registered |
| tc | output | 1 | High while the digit is at its last value (nine) |
| ceo | output | 1 | Carry to the next stage: `tc` AND `ce` |

## Verification
The bound checker watches single-stage behaviour on every cycle. It checks the clear, the increment, the hold, the wrap from nine, the return to 0 from an unused code, the agreement between the carry output and the terminal flag, and the flags staying low on unused codes. Some behaviour only the bench's scenarios can show. These are the power-up value, the recovery of every unused code (each started from its own power-up value), and the full 000 to 999 cascade run, in which the outputs of three stages act together.

// File: rtl/decade_pkg.sv
package decade_pkg;

  // Last value of a decimal digit
  localparam int DECIMAL_LAST = 9;

  // Action the register takes at the next rising edge
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_INC   = 2'd1,
    STEP_CLEAR = 2'd2
  } step_t;

endpackage

// File: rtl/decade_step_sel.sv
module decade_step_sel
  import decade_pkg::*;
#(
  parameter int LAST_VALUE = DECIMAL_LAST,
  parameter int W          = $clog2(LAST_VALUE + 1)
) (
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] cur_q,
  output step_t        step
);

  localparam logic [W-1:0] LAST_Q  = W'(LAST_VALUE);
  localparam bit           HAS_GAP = (LAST_VALUE != (1 << W) - 1);

  logic at_last;
  logic off_range;

  assign at_last = (cur_q == LAST_Q);

  // Unused codes exist only when the last value does not fill the width
  generate
    if (HAS_GAP) begin : g_gap
      assign off_range = (cur_q > LAST_Q);
    end else begin : g_full
      assign off_range = 1'b0;
    end
  endgenerate

  // Clear outranks everything; wrap and recovery both go to zero
  always_comb begin
    if (rst) begin
      step = STEP_CLEAR;
    end else if (!ce) begin
      step = STEP_HOLD;
    end else if (at_last || off_range) begin
      step = STEP_CLEAR;
    end else begin
      step = STEP_INC;
    end
  end

endmodule

// File: rtl/decade_next.sv
module decade_next
  import decade_pkg::*;
#(
  parameter int W = 4
) (
  input  step_t        step,
  input  logic [W-1:0] cur_q,
  output logic [W-1:0] nxt_q
);

  always_comb begin
    unique case (step)
      STEP_INC:   nxt_q = cur_q + W'(1);
      STEP_CLEAR: nxt_q = '0;
      default:    nxt_q = cur_q;
    endcase
  end

endmodule

// File: rtl/decade_term.sv
module decade_term #(
  parameter int LAST_VALUE = 9,
  parameter int W          = $clog2(LAST_VALUE + 1)
) (
  input  logic [W-1:0] cur_q,
  input  logic         ce,
  output logic         tc,
  output logic         ceo
);

  localparam logic [W-1:0] LAST_Q = W'(LAST_VALUE);

  // Exact match on every bit, so unused codes never raise the flag
  assign tc  = (cur_q == LAST_Q);
  assign ceo = tc & ce;

endmodule

// File: rtl/decade_counter.sv
module decade_counter
  import decade_pkg::*;
#(
  parameter int LAST_VALUE = DECIMAL_LAST,
  parameter int INIT_VALUE = 0,
  localparam int W         = $clog2(LAST_VALUE + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  output logic [W-1:0] q,
  output logic         tc,
  output logic         ceo
);

  step_t        step;
  logic [W-1:0] nxt_q;
  logic [W-1:0] count_q = W'(INIT_VALUE);

  decade_step_sel #(
    .LAST_VALUE(LAST_VALUE),
    .W         (W)
  ) step_sel_i (
    .rst  (rst),
    .ce   (ce),
    .cur_q(count_q),
    .step (step)
  );

  decade_next #(
    .W(W)
  ) next_i (
    .step (step),
    .cur_q(count_q),
    .nxt_q(nxt_q)
  );

  always_ff @(posedge clk) begin
    count_q <= nxt_q;
  end

  decade_term #(
    .LAST_VALUE(LAST_VALUE),
    .W         (W)
  ) term_i (
    .cur_q(count_q),
    .ce   (ce),
    .tc   (tc),
    .ceo  (ceo)
  );

  assign q = count_q;

endmodule

// File: rtl/decade_counter_chk.sv
module decade_counter_chk #(
  parameter int LAST_VALUE = 9,
  localparam int W         = $clog2(LAST_VALUE + 1)
) (
  input logic         clk,
  input logic         rst,
  input logic         ce,
  input logic [W-1:0] q,
  input logic         tc,
  input logic         ceo
);

  localparam logic [W-1:0] LAST_Q = W'(LAST_VALUE);

  logic rst_seen_q = 1'b0;

  always_ff @(posedge clk) begin
    rst_seen_q <= rst;
  end

  // R1: a clear edge leaves zero on every output
  always_ff @(posedge clk) begin
    if (rst_seen_q) begin
      a_r1_reset_clears: assert (q == '0 && !tc && !ceo)
        else $error("a_r1_reset_clears");
    end
  end

  a_r2_increment: assert property (@(posedge clk) disable iff (rst)
    (ce && q < LAST_Q) |=> (q == $past(q) + W'(1)));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> $stable(q));

  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (ce && q == LAST_Q) |=> (q == '0));

  a_r6_carry_needs_enable: assert property (@(posedge clk) disable iff (rst)
    ceo |-> (tc && ce));

  a_r6_carry_at_last: assert property (@(posedge clk) disable iff (rst)
    (tc && ce) |-> ceo);

  a_r7_flags_low_off_range: assert property (@(posedge clk) disable iff (rst)
    (q > LAST_Q) |-> (!tc && !ceo));

  a_r8_recover: assert property (@(posedge clk) disable iff (rst)
    (ce && q > LAST_Q) |=> (q == '0));

endmodule

bind decade_counter decade_counter_chk #(
  .LAST_VALUE(LAST_VALUE)
) chk_i (
  .clk(clk),
  .rst(rst),
  .ce (ce),
  .q  (q),
  .tc (tc),
  .ceo(ceo)
);

// File: tb/decade_counter_tb_top.sv
module decade_counter_tb_top;

  // {rst, ce, expected q after the edge}
  localparam int NVEC = 18;
  localparam logic [5:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 4'd0}, {1'b0, 1'b1, 4'd1}, {1'b0, 1'b0, 4'd1},
    {1'b0, 1'b1, 4'd2}, {1'b0, 1'b1, 4'd3}, {1'b0, 1'b1, 4'd4},
    {1'b0, 1'b0, 4'd4}, {1'b0, 1'b1, 4'd5}, {1'b0, 1'b1, 4'd6},
    {1'b0, 1'b1, 4'd7}, {1'b0, 1'b1, 4'd8}, {1'b0, 1'b1, 4'd9},
    {1'b0, 1'b0, 4'd9}, {1'b0, 1'b1, 4'd0}, {1'b0, 1'b1, 4'd1},
    {1'b1, 1'b1, 4'd0}, {1'b0, 1'b1, 4'd1}, {1'b1, 1'b0, 4'd0}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // unit under table test
  logic       rst = 1'b0, ce = 1'b0;
  logic [3:0] q;
  logic       tc, ceo;

  decade_counter dut_i (.clk(clk), .rst(rst), .ce(ce), .q(q), .tc(tc), .ceo(ceo));

  // three-stage cascade
  logic       ch_rst = 1'b0, ch_ce = 1'b0;
  logic [3:0] cq0, cq1, cq2;
  logic       ctc0, ctc1, ctc2, cco0, cco1, cco2;

  decade_counter ch0_i (.clk(clk), .rst(ch_rst), .ce(ch_ce), .q(cq0), .tc(ctc0), .ceo(cco0));
  decade_counter ch1_i (.clk(clk), .rst(ch_rst), .ce(cco0),  .q(cq1), .tc(ctc1), .ceo(cco1));
  decade_counter ch2_i (.clk(clk), .rst(ch_rst), .ce(cco1),  .q(cq2), .tc(ctc2), .ceo(cco2));

  // stages powering up in each unused code
  logic       rec_ce = 1'b0;
  logic [3:0] rec_q [6];
  logic [5:0] rec_tc, rec_co;

  for (genvar g = 0; g < 6; g++) begin : g_rec
    decade_counter #(.INIT_VALUE(10 + g)) rec_i (
      .clk(clk), .rst(1'b0), .ce(rec_ce),
      .q(rec_q[g]), .tc(rec_tc[g]), .ceo(rec_co[g]));
  end

  // clear from an unused code
  logic       rr_rst = 1'b0;
  logic [3:0] rr_q;
  logic       rr_tc, rr_co;

  decade_counter #(.INIT_VALUE(13)) rr_i (
    .clk(clk), .rst(rr_rst), .ce(1'b0), .q(rr_q), .tc(rr_tc), .ceo(rr_co));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int ref_q;
    int val;
    // power-up values before any edge
    #1;
    check("R9 power-up q", q, 0);
    check("R1 power-up tc", tc, 0);
    for (int g = 0; g < 6; g++) begin
      check("R9 power-up unused code", rec_q[g], 10 + g);
      check("R7 tc low on unused code", rec_tc[g], 0);
    end
    rec_ce = 1'b1;
    #1;
    for (int g = 0; g < 6; g++) check("R7 ceo low on unused code", rec_co[g], 0);
    rec_ce = 1'b0;
    rr_rst = 1'b1;

    // first edge at t=10: rec held, rr cleared
    @(negedge clk);
    rr_rst = 1'b0;
    for (int g = 0; g < 6; g++) check("R8 unused code held with ce low", rec_q[g], 10 + g);
    check("R8 clear from unused code", rr_q, 0);
    rec_ce = 1'b1;
    @(negedge clk);
    for (int g = 0; g < 6; g++) check("R8 recovery to zero", rec_q[g], 0);
    @(negedge clk);
    for (int g = 0; g < 6; g++) check("R8 normal count after recovery", rec_q[g], 1);
    rec_ce = 1'b0;

    // table walk
    ref_q = 0;
    for (int i = 0; i < NVEC; i++) begin
      rst = VEC[i][5];
      ce  = VEC[i][4];
      #1;
      check("R5 tc decode", tc, (ref_q == 9) ? 1 : 0);
      check("R6 ceo gating", ceo, (ref_q == 9 && ce) ? 1 : 0);
      @(negedge clk);
      if (VEC[i][5])               check("R1 clear", q, VEC[i][3:0]);
      else if (!VEC[i][4])         check("R3 hold", q, VEC[i][3:0]);
      else if (ref_q == 9)         check("R4 wrap", q, VEC[i][3:0]);
      else                         check("R2 increment", q, VEC[i][3:0]);
      ref_q = VEC[i][3:0];
      if (VEC[i][5]) check("R1 flags after clear", {tc, ceo}, 0);
    end

    // clear beats enable at nine
    rst = 1'b0; ce = 1'b1;
    for (int i = 0; i < 9; i++) @(negedge clk);
    check("R2 reach nine", q, 9);
    check("R5 tc at nine", tc, 1);
    ce = 1'b0;
    #1;
    check("R5 tc independent of ce", tc, 1);
    check("R6 ceo low with ce low", ceo, 0);
    rst = 1'b1; ce = 1'b1;
    @(negedge clk);
    check("R1 clear priority at nine", q, 0);
    rst = 1'b0; ce = 1'b0;

    // cascade 000..999 and wrap
    ch_rst = 1'b1;
    @(negedge clk);
    ch_rst = 1'b0;
    ch_ce  = 1'b1;
    check("R10 cascade start", cq2 * 100 + cq1 * 10 + cq0, 0);
    for (int i = 1; i <= 1000; i++) begin
      val = (i - 1) % 1000;
      #1;
      check("R10 top carry", cco2, (val == 999) ? 1 : 0);
      @(negedge clk);
      check("R10 cascade value", cq2 * 100 + cq1 * 10 + cq0, i % 1000);
    end
    ch_ce = 1'b0;
    @(negedge clk);
    check("R10 cascade hold", cq2 * 100 + cq1 * 10 + cq0, 0);

    finish_run();
  end

endmodule